// File: doc/BRIEF.md
# ADC Input Multiplexer Frame Sequencer

This block walks an analog input multiplexer through one conversion frame at a time. A frame is a run of time slots, and its length can be set from one to ten slots. The sequencer moves forward only on cycles where a 32768 Hz tick enable is high, while its registers run on the faster system clock. In each slot it drives a 4-bit input select code to the multiplexer. It also pulses a start strobe for the converter and FIR cycle. When a frame completes, it pulses a start strobe for one pass of the compute engine.

Two banks of slot codes are held at the input pins. The regular bank is used for every frame unless a host asks for an alternate frame. The host asks by raising a request bit. The rising edge is captured and held until the next frame boundary. At that boundary exactly one frame runs from the alternate bank, and after it the regular bank returns. An alternate-frame flag and the slot index are output so that downstream logic can fill in the regular samples that were skipped. Two more outputs are driven: a reference chopping signal, and a battery-monitor enable that is gated by a configuration bit.

Top module: `adc_frame_seq`

## Requirements
- R1: While reset is active and just after it, the slot index is 0, the frame is a regular frame, and the conversion strobe, compute strobe, chop output and battery enable are all low.
- R2: On a clock where `tick` is high, the slot index goes up by one, unless the frame ends. On any clock where `tick` is low, the slot index keeps its value.
- R3: The effective frame length is 1 when `frame_len` is 0, is equal to `frame_len` for values 1 to 10, and is 10 for larger values. On a tick with slot index ≥ length−1, the frame ends and the slot index returns to 0.
- R4: `mux_sel` shows the code of the current slot n. That code is bits [4n+3:4n] of `alt_bank` during an alternate frame and of `norm_bank` otherwise.
- R5: A rising edge on `alt_req` is held pending even if the bit drops on the next clock. Keeping the bit high does not create another request. Further edges that arrive while a request is pending merge into that one request.
- R6: A pending request never changes the current frame. The frame that starts at the next boundary is an alternate frame, and the request is then cleared, so the frame after that is regular again. If an edge arrives on the same clock as a boundary tick, it stays pending for the boundary after that.
- R7: `conv_start` is high for exactly the one clock that follows each tick. `ce_start` is high for exactly the one clock that follows a frame-ending tick, and in that clock `conv_start` is high and the slot index is 0.
- R8: `bat_mon_en` is high exactly when `bat_en_cfg` is 1, the current frame is an alternate frame, and the current slot code equals the battery code 4'hB.
- R9: `chop_mode` selects the chop behaviour: 00 holds the output, 01 forces it low, 10 forces it high, and 11 toggles it once at every frame end. The output follows the mode one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Slot-advance enable at 32768 Hz |
| alt_req | input | 1 | Host request bit for one alternate frame |
| frame_len | input | LEN_W | Slots per frame (clamped to 1..NSLOT) |
| norm_bank | input | NSLOT*SEL_W | Regular slot codes, slot n in bits [SEL_W*n +: SEL_W] |
| alt_bank | input | NSLOT*SEL_W | Alternate slot codes, same packing |
| chop_mode | input | 2 | Reference chop mode |
| bat_en_cfg | input | 1 | Battery monitor allowed |
| mux_sel | output | SEL_W | Input select code for the multiplexer |
| slot_idx | output | IDX_W | Current slot index |
| alt_frame | output | 1 | Current frame uses the alternate bank |
| conv_start | output | 1 | Converter/FIR cycle start pulse |
| ce_start | output | 1 | Compute engine pass start pulse |
| chop_out | output | 1 | Reference chop control |
| bat_mon_en | output | 1 | Battery monitor enable |

## Verification
A host request edge can arrive on the very clock where the frame-ending tick switches the bank. That is the case most likely to go wrong. The bench steps the sequencer to the last slot of a frame and then raises `alt_req` and `tick` together. It requires the frame that just starts to stay regular and the frame after it to be the only alternate one. The sweep covers every `frame_len` value and every chop mode, using single, held and merged request edges. Each output is compared, every clock, against a model built from the requirements.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        CHOP_HOLD   = 2'b00,
        CHOP_LOW    = 2'b01,
        CHOP_HIGH   = 2'b10,
        CHOP_TOGGLE = 2'b11
    } chop_mode_e;

    // Index of the last slot for a raw length field, clamped to 1..nslot slots.
    function automatic int unsigned last_slot(input int unsigned len, input int unsigned nslot);
        if (len == 0)
            return 0;
        else if (len > nslot)
            return nslot - 1;
        else
            return len - 1;
    endfunction

endpackage

// File: rtl/adc_seq_req.sv
module adc_seq_req (
    input  logic clk,
    input  logic rst_n,
    input  logic alt_req,
    input  logic take,
    output logic pending
);
    typedef struct packed {
        logic prev;
        logic pend;
    } req_st_t;

    req_st_t st_d, st_q;
    logic    rise;

    always_comb begin
        st_d      = st_q;
        rise      = alt_req & ~st_q.prev;
        st_d.prev = alt_req;
        // An edge on the consuming clock stays armed for the following frame.
        st_d.pend = rise | (st_q.pend & ~take);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign pending = st_q.pend;
endmodule

// File: rtl/adc_seq_slot.sv
module adc_seq_slot #(
    parameter int NSLOT = 10,
    parameter int LEN_W = 4,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [LEN_W-1:0] frame_len,
    input  logic             pending,
    output logic [IDX_W-1:0] slot,
    output logic             alt,
    output logic             boundary,
    output logic             conv_start,
    output logic             ce_start
);
    import adc_seq_pkg::*;

    typedef struct packed {
        logic [IDX_W-1:0] slot;
        logic             alt;
        logic             conv;
        logic             ce;
    } slot_st_t;

    slot_st_t         st_d, st_q;
    logic [IDX_W-1:0] last;
    logic             bnd;

    always_comb begin
        last    = IDX_W'(last_slot(32'(frame_len), NSLOT));
        bnd     = tick && (st_q.slot >= last);
        st_d    = st_q;
        st_d.conv = tick;
        st_d.ce   = bnd;
        if (tick) begin
            if (bnd) begin
                st_d.slot = '0;
                st_d.alt  = pending;
            end else begin
                st_d.slot = st_q.slot + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign slot       = st_q.slot;
    assign alt        = st_q.alt;
    assign boundary   = bnd;
    assign conv_start = st_q.conv;
    assign ce_start   = st_q.ce;
endmodule

// File: rtl/adc_seq_chop.sv
module adc_seq_chop (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       boundary,
    input  logic [1:0] mode,
    output logic       chop
);
    import adc_seq_pkg::*;

    typedef struct packed {
        logic level;
    } chop_st_t;

    chop_st_t   st_d, st_q;
    chop_mode_e m;

    always_comb begin
        m    = chop_mode_e'(mode);
        st_d = st_q;
        unique case (m)
            CHOP_HOLD:   st_d.level = st_q.level;
            CHOP_LOW:    st_d.level = 1'b0;
            CHOP_HIGH:   st_d.level = 1'b1;
            CHOP_TOGGLE: st_d.level = st_q.level ^ boundary;
            default:     st_d.level = st_q.level;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign chop = st_q.level;
endmodule

// File: rtl/adc_frame_seq.sv
module adc_frame_seq #(
    parameter int          NSLOT    = 10,
    parameter int          SEL_W    = 4,
    parameter int          LEN_W    = 4,
    parameter logic [3:0]  BAT_CODE = 4'hB,
    parameter int          IDX_W    = $clog2(NSLOT)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tick,
    input  logic                   alt_req,
    input  logic [LEN_W-1:0]       frame_len,
    input  logic [NSLOT*SEL_W-1:0] norm_bank,
    input  logic [NSLOT*SEL_W-1:0] alt_bank,
    input  logic [1:0]             chop_mode,
    input  logic                   bat_en_cfg,
    output logic [SEL_W-1:0]       mux_sel,
    output logic [IDX_W-1:0]       slot_idx,
    output logic                   alt_frame,
    output logic                   conv_start,
    output logic                   ce_start,
    output logic                   chop_out,
    output logic                   bat_mon_en
);
    logic             pending;
    logic             boundary;
    logic [IDX_W-1:0] slot;
    logic             alt;
    logic [SEL_W-1:0] norm_arr [NSLOT];
    logic [SEL_W-1:0] alt_arr  [NSLOT];
    logic [SEL_W-1:0] norm_cur, alt_cur;

    adc_seq_req i_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .alt_req (alt_req),
        .take    (boundary),
        .pending (pending)
    );

    adc_seq_slot #(.NSLOT(NSLOT), .LEN_W(LEN_W), .IDX_W(IDX_W)) i_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .frame_len  (frame_len),
        .pending    (pending),
        .slot       (slot),
        .alt        (alt),
        .boundary   (boundary),
        .conv_start (conv_start),
        .ce_start   (ce_start)
    );

    adc_seq_chop i_chop (
        .clk      (clk),
        .rst_n    (rst_n),
        .boundary (boundary),
        .mode     (chop_mode),
        .chop     (chop_out)
    );

    for (genvar n = 0; n < NSLOT; n++) begin : g_unpack
        assign norm_arr[n] = norm_bank[n*SEL_W +: SEL_W];
        assign alt_arr[n]  = alt_bank[n*SEL_W +: SEL_W];
    end

    always_comb begin
        norm_cur = '0;
        alt_cur  = '0;
        for (int n = 0; n < NSLOT; n++) begin
            if (slot == IDX_W'(n)) begin
                norm_cur = norm_arr[n];
                alt_cur  = alt_arr[n];
            end
        end
    end

    assign mux_sel    = alt ? alt_cur : norm_cur;
    assign slot_idx   = slot;
    assign alt_frame  = alt;
    assign bat_mon_en = bat_en_cfg & alt & (alt_cur == SEL_W'(BAT_CODE));
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
    parameter int NSLOT = 10,
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic [1:0]       chop_mode,
    input logic             bat_en_cfg,
    input logic [IDX_W-1:0] slot_idx,
    input logic             alt_frame,
    input logic             conv_start,
    input logic             ce_start,
    input logic             chop_out,
    input logic             bat_mon_en
);
    // R2: no tick, no slot movement
    a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(slot_idx));

    // R3: slot index stays inside the slot table
    a_r3_slot_in_table: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, slot_idx} < (IDX_W+1)'(NSLOT));

    // R6: bank choice changes only at a frame start
    a_r6_bank_fixed_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_start |-> $stable(alt_frame));

    // R7: compute pass starts together with slot 0 conversion
    a_r7_ce_with_slot0: assert property (@(posedge clk) disable iff (!rst_n)
        ce_start |-> (conv_start && slot_idx == '0));

    // R7: a conversion start always follows a tick
    a_r7_conv_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> $past(tick));

    // R8: battery enable only in alternate frames with the bit set
    a_r8_bat_gated: assert property (@(posedge clk) disable iff (!rst_n)
        bat_mon_en |-> (alt_frame && bat_en_cfg));

    // R9: forced chop levels
    a_r9_chop_high: assert property (@(posedge clk) disable iff (!rst_n)
        (chop_mode == 2'b10) |=> chop_out);
    a_r9_chop_low: assert property (@(posedge clk) disable iff (!rst_n)
        (chop_mode == 2'b01) |=> !chop_out);
endmodule

bind adc_frame_seq adc_seq_chk #(.NSLOT(NSLOT), .IDX_W(IDX_W)) i_chk (.*);

// File: tb/test_adc_frame_seq.sv
module test_adc_frame_seq;
    localparam int NSLOT = 10;
    localparam int SEL_W = 4;

    logic                   clk = 1'b0;
    logic                   rst_n;
    logic                   tick;
    logic                   alt_req;
    logic [3:0]             frame_len;
    logic [NSLOT*SEL_W-1:0] norm_bank;
    logic [NSLOT*SEL_W-1:0] alt_bank;
    logic [1:0]             chop_mode;
    logic                   bat_en_cfg;
    logic [SEL_W-1:0]       mux_sel;
    logic [3:0]             slot_idx;
    logic                   alt_frame, conv_start, ce_start, chop_out, bat_mon_en;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // reference model state
    int mslot = 0, malt = 0, mpend = 0, mprev = 0, mchop = 0, mconv = 0, mce = 0;

    always #10 clk = ~clk;

    adc_frame_seq i_adc_frame_seq (
        .clk(clk), .rst_n(rst_n), .tick(tick), .alt_req(alt_req),
        .frame_len(frame_len), .norm_bank(norm_bank), .alt_bank(alt_bank),
        .chop_mode(chop_mode), .bat_en_cfg(bat_en_cfg), .mux_sel(mux_sel),
        .slot_idx(slot_idx), .alt_frame(alt_frame), .conv_start(conv_start),
        .ce_start(ce_start), .chop_out(chop_out), .bat_mon_en(bat_mon_en)
    );

    function automatic int norm_code(int n); return (3*n + 1) % 16; endfunction
    function automatic int alt_code(int n);  return (5*n + 2) % 16; endfunction
    function automatic int lastof(int l);
        if (l == 0) return 0;
        if (l > NSLOT) return NSLOT - 1;
        return l - 1;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_all();
        int code;
        code = (malt != 0) ? alt_code(mslot) : norm_code(mslot);
        check("R2/R3 slot_idx", int'(slot_idx), mslot);
        check("R6 alt_frame", int'(alt_frame), malt);
        check("R4 mux_sel", int'(mux_sel), code);
        check("R7 conv_start", int'(conv_start), mconv);
        check("R7 ce_start", int'(ce_start), mce);
        check("R9 chop_out", int'(chop_out), mchop);
        check("R8 bat_mon_en", int'(bat_mon_en),
              (bat_en_cfg && malt != 0 && alt_code(mslot) == 11) ? 1 : 0);
    endtask

    // One clock: drive at negedge, update model, sample at the following negedge.
    task automatic cyc(input bit t, input bit r);
        int rise, bnd;
        tick    = t;
        alt_req = r;
        rise  = (r && mprev == 0) ? 1 : 0;
        mprev = r;
        bnd   = (t && mslot >= lastof(int'(frame_len))) ? 1 : 0;
        mconv = t;
        mce   = bnd;
        case (chop_mode)
            2'b01: mchop = 0;
            2'b10: mchop = 1;
            2'b11: if (bnd != 0) mchop = 1 - mchop;
            default: ;
        endcase
        if (t) mslot = (bnd != 0) ? 0 : mslot + 1;
        if (bnd != 0) begin
            malt  = mpend;
            mpend = rise;
        end else begin
            mpend = (mpend != 0 || rise != 0) ? 1 : 0;
        end
        @(posedge clk);
        @(negedge clk);
        check_all();
    endtask

    initial begin
        #4000000;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; tick = 0; alt_req = 0; frame_len = 4'd10;
        chop_mode = 2'b00; bat_en_cfg = 1'b1;
        for (int n = 0; n < NSLOT; n++) begin
            norm_bank[n*SEL_W +: SEL_W] = 4'(norm_code(n));
            alt_bank[n*SEL_W +: SEL_W]  = 4'(alt_code(n));
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1 slot_idx", int'(slot_idx), 0);
        check("R1 alt_frame", int'(alt_frame), 0);
        check("R1 conv_start", int'(conv_start), 0);
        check("R1 ce_start", int'(ce_start), 0);
        check("R1 chop_out", int'(chop_out), 0);
        check("R1 bat_mon_en", int'(bat_mon_en), 0);
        rst_n = 1'b1;
        cyc(0, 0);

        for (int len = 0; len < 16; len++) begin
            for (int m = 0; m < 4; m++) begin
                frame_len  = 4'(len);
                chop_mode  = 2'(m);
                bat_en_cfg = (len % 3 != 0);
                // R2/R3: plain ticking with idle clocks between ticks
                for (int k = 0; k < 24; k++) begin cyc(1, 0); cyc(0, 0); end
                // R5: edge, held level, drop, second edge merged
                cyc(0, 1); cyc(0, 1); cyc(0, 0); cyc(1, 1); cyc(0, 0);
                // R6: one alternate frame, then regular
                for (int k = 0; k < 24; k++) cyc(1, 0);
                // R6: edge on the frame-ending tick
                while (mslot != lastof(len)) cyc(1, 0);
                cyc(1, 1);
                cyc(0, 0);
                for (int k = 0; k < 24; k++) cyc(1, 0);
            end
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule